// File: doc/BRIEF.md
# Hardware Return-Address Stack

This block keeps the return addresses of a small 8-bit controller core in a fixed set of six registers. A subroutine call or an accepted interrupt pushes the current program counter. Either of the two return strobes pops the newest entry back out as the restored program counter. Nothing else can see or change the stack: there is no data-bus path to its entries or to its pointer.

The block also decides whether an interrupt can be accepted. If a request arrives while all six levels are in use, it is held in a pending flag and not acknowledged. The first cycle after a return has freed a level, the held request is acknowledged and pushed.

A call made on a full stack always goes ahead and drops the oldest entry, so the six most recent return addresses survive. A return on an empty stack changes nothing. A push and a pop requested in the same cycle are treated as an illegal combination, and both are discarded.

Top module: `ret_addr_stack`

## Requirements
- R1: While reset is active and after it is released, the stack is empty: `full_o` is 0, `irq_pend_o` is 0, `irq_ack_o` is 0 and `pc_o` is 0.
- R2: A cycle with `call_i` high (no return strobe) pushes `pc_i`. A later pop returns the entries in last-in first-out order, and `pc_o` shows the popped value from the clock edge that ends the pop cycle.
- R3: `ret_i` and `reti_i` each perform the same single pop, and raising both in one cycle is one pop.
- R4: `full_o` is 1 exactly when the stack holds six entries.
- R5: A call on a full stack overwrites the oldest entry. The stack stays full, and the following six pops return the six most recent addresses, newest first.
- R6: An interrupt request (`irq_i`, or the held pending flag) in a cycle with the stack not full and no call or return strobe raises `irq_ack_o` in that same cycle and pushes `pc_i`.
- R7: An interrupt request while the stack is full raises no acknowledge and sets `irq_pend_o` from the next edge. Once a return has freed a level, the first cycle without a call or return strobe acknowledges it and clears the flag.
- R8: An interrupt request in a cycle that carries a call or return strobe is not acknowledged in that cycle. It is held pending instead.
- R9: A pop on an empty stack leaves the occupancy unchanged and `pc_o` holds its previous value (0 if nothing was ever popped).
- R10: A call together with `ret_i` or `reti_i` in the same cycle pushes nothing and pops nothing. `pc_o` and `full_o` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| call_i | input | 1 | Subroutine call: push request |
| irq_i | input | 1 | Unmasked interrupt request |
| ret_i | input | 1 | Return from subroutine: pop request |
| reti_i | input | 1 | Return from interrupt: pop request |
| pc_i | input | PC_W | Current program counter, the value pushed |
| pc_o | output | PC_W | Restored program counter from the last effective pop |
| irq_ack_o | output | 1 | Interrupt accepted this cycle |
| irq_pend_o | output | 1 | Interrupt request held, not yet accepted |
| full_o | output | 1 | Six entries held |

## Verification
Some rules are checked by assertions on every cycle:
- the occupancy never exceeds six;
- no acknowledge is given while the stack is full or while a call or return is under way;
- a refused request stays pending;
- a push onto a full stack keeps it full;
- an empty pop moves nothing;
- a call that clashes with a return changes neither the restored PC nor the full flag.

Other behaviour is visible only across a sequence, so only the bench scenarios can show it:
- last-in first-out ordering;
- survival of exactly the six newest addresses after an overflowing call;
- the late acknowledge of a held interrupt after a return.

The bench shows these through a reference model stepped over sweeps of push depths and a long pseudo-random stream.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [1:0] {
    RAS_IDLE  = 2'd0,
    RAS_PUSH  = 2'd1,
    RAS_POP   = 2'd2,
    RAS_CLASH = 2'd3
  } ras_op_e;

  function automatic ras_op_e ras_classify(input logic push_req, input logic pop_req);
    ras_op_e op;
    case ({push_req, pop_req})
      2'b10:   op = RAS_PUSH;
      2'b01:   op = RAS_POP;
      2'b11:   op = RAS_CLASH;
      default: op = RAS_IDLE;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/ras_rst_sync.sv
module ras_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ras_ptr_ctl.sv
module ras_ptr_ctl #(
  parameter  int DEPTH = 6,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] top_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(DEPTH);

  logic [IDX_W-1:0] top_q, top_d, nxt_idx, prv_idx;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;

  always_comb begin
    nxt_idx = (top_q == LAST_IDX) ? '0 : top_q + 1'b1;
    prv_idx = (top_q == '0) ? LAST_IDX : top_q - 1'b1;
  end

  assign full_o   = (cnt_q == MAX_CNT);
  assign empty_o  = (cnt_q == '0);
  assign wr_idx_o = nxt_idx;
  assign top_o    = top_q;
  assign upd_en   = push_i | (pop_i & ~empty_o);

  always_comb begin
    top_d = top_q;
    cnt_d = cnt_q;
    if (push_i) begin
      top_d = nxt_idx;
      if (!full_o) cnt_d = cnt_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      top_d = prv_idx;
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= LAST_IDX;
      cnt_q <= '0;
    end else if (upd_en) begin
      top_q <= top_d;
      cnt_q <= cnt_d;
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAX_CNT);

  // R5
  full_push_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_o && push_i |=> full_o);

  // R9
  empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o && pop_i && !push_i |=> empty_o && $stable(top_q));
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter  int PC_W  = 13,
  parameter  int DEPTH = 6,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [PC_W-1:0]  wdata_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [PC_W-1:0]  rdata_o
);
  logic [PC_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = we_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx_i == IDX_W'(i)) rdata_o = slot_q[i];
    end
  end
endmodule

// File: rtl/ras_irq_gate.sv
module ras_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_i,
  input  logic busy_i,
  input  logic full_i,
  output logic ack_o,
  output logic pend_o
);
  logic pend_q, pend_d, req;

  assign req    = irq_i | pend_q;
  assign ack_o  = req & ~full_i & ~busy_i;
  assign pend_d = req & ~ack_o;
  assign pend_o = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  // R7
  no_ack_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> !full_i);

  // R7
  held_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i || pend_q) && full_i |=> pend_q);

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> !ack_o);
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int PC_W  = 13,
  parameter int DEPTH = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_i,
  input  logic            irq_i,
  input  logic            ret_i,
  input  logic            reti_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [PC_W-1:0] pc_o,
  output logic            irq_ack_o,
  output logic            irq_pend_o,
  output logic            full_o
);
  import ras_pkg::*;

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             rst_int_n;
  logic             pop_req, busy, push_en, pop_en, ack, full, empty;
  logic [IDX_W-1:0] top_idx, wr_idx;
  logic [PC_W-1:0]  rd_data, pc_q, pc_d;
  ras_op_e          op;

  ras_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign pop_req = ret_i | reti_i;
  assign busy    = call_i | pop_req;
  assign op      = ras_classify(call_i, pop_req);
  assign push_en = (op == RAS_PUSH) | ack;
  assign pop_en  = (op == RAS_POP);

  ras_irq_gate u_irq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .irq_i  (irq_i),
    .busy_i (busy),
    .full_i (full),
    .ack_o  (ack),
    .pend_o (irq_pend_o)
  );

  ras_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .push_i   (push_en),
    .pop_i    (pop_en),
    .top_o    (top_idx),
    .wr_idx_o (wr_idx),
    .full_o   (full),
    .empty_o  (empty)
  );

  ras_store #(.PC_W(PC_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .we_i     (push_en),
    .wr_idx_i (wr_idx),
    .wdata_i  (pc_i),
    .rd_idx_i (top_idx),
    .rdata_o  (rd_data)
  );

  always_comb begin
    pc_d = pc_q;
    if (pop_en && !empty) pc_d = rd_data;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) pc_q <= '0;
    else            pc_q <= pc_d;
  end

  assign pc_o      = pc_q;
  assign irq_ack_o = ack;
  assign full_o    = full;

  // R10
  clash_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    call_i && (ret_i || reti_i) |=> $stable(pc_o) && $stable(full_o));

  // R6
  ack_pushes_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_ack_o |-> !call_i && !ret_i && !reti_i);
endmodule

// File: tb/ret_addr_stack_tb.sv
module ret_addr_stack_tb;
  localparam int PC_W  = 13;
  localparam int DEPTH = 6;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            call_i, irq_i, ret_i, reti_i;
  logic [PC_W-1:0] pc_i;
  logic [PC_W-1:0] pc_o;
  logic            irq_ack_o, irq_pend_o, full_o;

  int n_run  = 0;
  int n_fail = 0;

  logic [PC_W-1:0] mdl [DEPTH];
  int              mcnt;
  bit              mpend;
  logic [PC_W-1:0] mpc;

  always #4 clk = ~clk;

  ret_addr_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .irq_i(irq_i),
    .ret_i(ret_i), .reti_i(reti_i), .pc_i(pc_i), .pc_o(pc_o),
    .irq_ack_o(irq_ack_o), .irq_pend_o(irq_pend_o), .full_o(full_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One cycle of stimulus; reference model updated from the requirements.
  task automatic step(input string tag, input bit c, input bit r, input bit ri,
                      input bit q, input logic [PC_W-1:0] pc);
    bit pop, clash, busy, req, eack, psh, dpop;
    @(negedge clk);
    call_i = c; ret_i = r; reti_i = ri; irq_i = q; pc_i = pc;
    #1;
    pop   = r | ri;
    clash = c & pop;
    busy  = c | pop;
    req   = q | mpend;
    eack  = req & (mcnt != DEPTH) & !busy;
    psh   = (c & !clash) | eack;
    dpop  = pop & !clash;
    chk(tag, "irq_ack_o", 32'(irq_ack_o), 32'(eack));
    if (psh) begin
      if (mcnt == DEPTH) begin
        for (int i = 0; i < DEPTH - 1; i++) mdl[i] = mdl[i+1];
        mdl[DEPTH-1] = pc;
      end else begin
        mdl[mcnt] = pc;
        mcnt++;
      end
    end else if (dpop && mcnt > 0) begin
      mpc = mdl[mcnt-1];
      mcnt--;
    end
    mpend = req & !eack;
    @(posedge clk);
    #1;
    call_i = 0; ret_i = 0; reti_i = 0; irq_i = 0;
    chk(tag, "full_o", 32'(full_o), 32'(mcnt == DEPTH));
    chk(tag, "irq_pend_o", 32'(irq_pend_o), 32'(mpend));
    chk(tag, "pc_o", 32'(pc_o), 32'(mpc));
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 0; call_i = 0; irq_i = 0; ret_i = 0; reti_i = 0; pc_i = '0;
    mcnt = 0; mpend = 0; mpc = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs during reset
    chk("R1", "full_o", 32'(full_o), 0);
    chk("R1", "irq_pend_o", 32'(irq_pend_o), 0);
    chk("R1", "irq_ack_o", 32'(irq_ack_o), 0);
    chk("R1", "pc_o", 32'(pc_o), 0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "pc_o after release", 32'(pc_o), 0);
    chk("R1", "full_o after release", 32'(full_o), 0);

    // R9: pops on empty keep pc_o at zero
    step("R9", 0, 1, 0, 0, '0);
    step("R9", 0, 0, 1, 0, '0);
    step("R9", 0, 1, 1, 0, '0);

    // R2 R3 R4 R5: sweep of push depths, drain with alternating strobes
    for (int n = 1; n <= 9; n++) begin
      for (int k = 0; k < n; k++)
        step((n > DEPTH) ? "R5" : "R4", 1, 0, 0, 0, PC_W'(13'h100 + n * 16 + k));
      for (int k = 0; k <= n; k++)
        step((k == n) ? "R9" : "R3", 0, (k % 3) != 1, (k % 3) != 0, 0, '0);
    end

    // R6: interrupt on non-full stack is acknowledged and pushed
    step("R6", 0, 0, 0, 1, 13'h0abc);
    step("R2", 1, 0, 0, 0, 13'h0123);
    step("R2", 0, 1, 0, 0, '0);
    step("R6", 0, 0, 1, 0, '0);

    // R7: interrupt on full stack pends until a return frees a level
    for (int k = 0; k < DEPTH; k++) step("R4", 1, 0, 0, 0, PC_W'(13'h1f00 + k));
    step("R7", 0, 0, 0, 1, 13'h0777);
    step("R7", 0, 0, 0, 0, 13'h0666);
    step("R7", 0, 1, 0, 0, '0);
    step("R7", 0, 0, 0, 0, 13'h0555);
    step("R7", 0, 0, 1, 0, '0);

    // R8: interrupt alongside call or return is deferred
    step("R8", 1, 0, 0, 1, 13'h0321);
    step("R8", 0, 0, 0, 0, 13'h0432);
    step("R8", 0, 1, 0, 1, '0);
    step("R8", 0, 0, 0, 0, 13'h0543);

    // R10: clashing push and pop are both dropped
    step("R10", 1, 1, 0, 0, 13'h1111);
    step("R10", 1, 0, 1, 0, 13'h1222);
    step("R10", 1, 1, 1, 0, 13'h1333);
    for (int k = 0; k < 8; k++) step("R10", 0, 1, 0, 0, '0);

    // R2: pseudo-random stream against the model
    lfsr = 16'hace1;
    for (int k = 0; k < 4000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R2", lfsr[0] & lfsr[1], lfsr[2] & ~lfsr[3], lfsr[4] & lfsr[5] & lfsr[3],
           lfsr[6] & lfsr[7] & lfsr[8], PC_W'(lfsr));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule